// File: doc/BRIEF.md
# Per-Key Access Rights Guard

This block decides whether a user-mode memory access may proceed, based on a small rights table indexed by a key. Each request presents a 64-bit paging-structure entry, the access kind (read or write), whether the page is a user page, and a global enable. The block takes a 4-bit key from the entry. It looks up that key's two rights bits in a 32-bit register and, one clock later, returns an allow/deny decision with a page-fault error code.

The rights register has two ways in. The first is a pair of instruction-style read and write ports, each qualified by a selector operand. The second is a whole-register load and image used by state save/restore. A selector other than zero makes an instruction-style access illegal: the register stays unchanged and a general-protection fault flag is raised.

Top module: `pkey_guard`

## Requirements
- R1: The key of an access is bits 62:59 of `acc_entry`. Key k is governed by rights bits 2k (access-disable) and 2k+1 (write-disable).
- R2: With checking active, a user access whose key has its access-disable bit set is denied, whether it is a read or a write.
- R3: With checking active, a user access whose key has only its write-disable bit set is allowed as a read and denied as a write.
- R4: When `gate_en` is 0, every access is allowed.
- R5: An access with `acc_is_user` = 0 is always allowed.
- R6: A denied access reports error code 0x0025 for a read and 0x0027 for a write (bit 0 present, bit 1 write, bit 2 user, bit 5 key violation). Any other cycle reports 0.
- R7: `dec_valid`, `dec_allow` and `dec_errcode` appear one cycle after the request. `dec_allow` is 0 in a cycle with no request.
- R8: After reset, the rights register, `ss_image`, `rr_rd_data`, `rr_gp_fault` and all decision outputs are 0.
- R9: A register write with `rr_sel` = 0 updates the register at the next edge. An access requested in the same cycle as the write sees the old rights, and one requested in the next cycle sees the new rights.
- R10: A register read or write with `rr_sel` not 0 leaves the register unchanged and pulses `rr_gp_fault` in the next cycle.
- R11: A register read with `rr_sel` = 0 shows the register value, as it was before that edge, on `rr_rd_data` in the next cycle. `rr_rd_data` holds at all other times.
- R12: `ss_load_en` replaces the whole register at the next edge and takes priority over a register write in the same cycle. `ss_image` always shows the current register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Access request present |
| acc_entry | input | 64 | Paging-structure entry that maps the page |
| acc_is_write | input | 1 | 1 for a write access, 0 for a read |
| acc_is_user | input | 1 | 1 when the page is a user page |
| gate_en | input | 1 | Global key-check enable |
| dec_valid | output | 1 | Decision present |
| dec_allow | output | 1 | Access allowed |
| dec_errcode | output | 16 | Page-fault error code |
| rr_wr_en | input | 1 | Instruction-style register write |
| rr_rd_en | input | 1 | Instruction-style register read |
| rr_sel | input | 32 | Selector operand, legal only when 0 |
| rr_wr_data | input | 32 | Write value |
| rr_rd_data | output | 32 | Read result |
| rr_gp_fault | output | 1 | Illegal-selector fault pulse |
| ss_load_en | input | 1 | Whole-register restore |
| ss_load_data | input | 32 | Restore value |
| ss_image | output | 32 | Current register for save |

## Verification
Directed cases first run each rights combination on a few keys: access-disable, write-disable, both, and neither. Each is tried as a read and as a write. This separates the two rights bits and shows that the key is taken from the correct entry bits, because neighbouring keys are loaded with different rights. The same denials are then repeated with `gate_en` clear and with supervisor pages, which separates the two bypass conditions from the rights lookup. Write-then-access pairs, illegal selectors, and a restore colliding with a write cover register timing and priority. A long random run with mostly legal selectors then mixes all of these.

// File: rtl/pkey_pkg.sv
package pkey_pkg;

   // Rights pair for one key; access-disable sits in the low bit.
   typedef struct packed {
      logic wd;
      logic ad;
   } key_rights_t;

   localparam int ERR_PRESENT_BIT = 0;
   localparam int ERR_WRITE_BIT   = 1;
   localparam int ERR_USER_BIT    = 2;
   localparam int ERR_KEY_BIT     = 5;

endpackage

// File: rtl/pkey_rights_reg.sv
module pkey_rights_reg #(
   parameter int KEYS  = 16,
   parameter int SEL_W = 32,
   localparam int RW   = 2 * KEYS
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic             rd_en,
   input  logic [SEL_W-1:0] sel,
   input  logic [RW-1:0]    wr_data,
   input  logic             ld_en,
   input  logic [RW-1:0]    ld_data,
   output logic [RW-1:0]    rights,
   output logic [RW-1:0]    rd_data,
   output logic             gp_fault
);

   logic sel_ok;
   assign sel_ok = (sel == '0);

   // Restore path wins over the instruction write.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rights <= '0;
      else if (ld_en)
         rights <= ld_data;
      else if (wr_en && sel_ok)
         rights <= wr_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_data  <= '0;
         gp_fault <= 1'b0;
      end else begin
         gp_fault <= (wr_en || rd_en) && !sel_ok;
         if (rd_en && sel_ok)
            rd_data <= rights;
      end
   end

endmodule

// File: rtl/pkey_lookup.sv
module pkey_lookup
   import pkey_pkg::*;
#(
   parameter int ENTRY_W = 64,
   parameter int KEY_LSB = 59,
   parameter int KEY_W   = 4,
   parameter bit DECODED = 1'b1,
   localparam int KEYS   = 1 << KEY_W,
   localparam int RW     = 2 * KEYS
) (
   input  logic [ENTRY_W-1:0] entry,
   input  logic [RW-1:0]      rights,
   output logic               ad,
   output logic               wd
);

   logic [KEY_W-1:0] key;
   logic             unused_entry;

   assign key          = entry[KEY_LSB +: KEY_W];
   assign unused_entry = ^entry;

   generate
      if (DECODED) begin : g_decoded
         // One-hot key decode feeding an AND-OR tree.
         logic [KEYS-1:0] hit_ad;
         logic [KEYS-1:0] hit_wd;
         for (genvar i = 0; i < KEYS; i++) begin : g_key
            key_rights_t pair;
            assign pair      = rights[2*i +: 2];
            assign hit_ad[i] = (key == KEY_W'(i)) && pair.ad;
            assign hit_wd[i] = (key == KEY_W'(i)) && pair.wd;
         end
         assign ad = |hit_ad;
         assign wd = |hit_wd;
      end else begin : g_muxed
         key_rights_t pair;
         assign pair = rights[2*key +: 2];
         assign ad   = pair.ad;
         assign wd   = pair.wd;
      end
   endgenerate

endmodule

// File: rtl/pkey_decide.sv
module pkey_decide
   import pkey_pkg::*;
#(
   parameter int ERR_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             acc_valid,
   input  logic             is_write,
   input  logic             is_user,
   input  logic             gate_en,
   input  logic             ad,
   input  logic             wd,
   output logic             dec_valid,
   output logic             dec_allow,
   output logic [ERR_W-1:0] dec_errcode
);

   logic             deny;
   logic [ERR_W-1:0] code;

   assign deny = gate_en && is_user && (ad || (wd && is_write));

   always_comb begin
      code                  = '0;
      code[ERR_PRESENT_BIT] = 1'b1;
      code[ERR_WRITE_BIT]   = is_write;
      code[ERR_USER_BIT]    = is_user;
      code[ERR_KEY_BIT]     = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dec_valid   <= 1'b0;
         dec_allow   <= 1'b0;
         dec_errcode <= '0;
      end else begin
         dec_valid   <= acc_valid;
         dec_allow   <= acc_valid && !deny;
         dec_errcode <= (acc_valid && deny) ? code : '0;
      end
   end

endmodule

// File: rtl/pkey_guard.sv
module pkey_guard #(
   parameter int ENTRY_W        = 64,
   parameter int KEY_LSB        = 59,
   parameter int KEY_W          = 4,
   parameter int SEL_W          = 32,
   parameter int ERR_W          = 16,
   parameter bit LOOKUP_DECODED = 1'b1,
   localparam int KEYS          = 1 << KEY_W,
   localparam int RIGHTS_W      = 2 * KEYS
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                acc_valid,
   input  logic [ENTRY_W-1:0]  acc_entry,
   input  logic                acc_is_write,
   input  logic                acc_is_user,
   input  logic                gate_en,
   output logic                dec_valid,
   output logic                dec_allow,
   output logic [ERR_W-1:0]    dec_errcode,
   input  logic                rr_wr_en,
   input  logic                rr_rd_en,
   input  logic [SEL_W-1:0]    rr_sel,
   input  logic [RIGHTS_W-1:0] rr_wr_data,
   output logic [RIGHTS_W-1:0] rr_rd_data,
   output logic                rr_gp_fault,
   input  logic                ss_load_en,
   input  logic [RIGHTS_W-1:0] ss_load_data,
   output logic [RIGHTS_W-1:0] ss_image
);

   generate
      if (KEY_LSB + KEY_W > ENTRY_W) begin : g_bad_key
         $error("key field lies outside the entry");
      end
      if (ERR_W < 6) begin : g_bad_err
         $error("error code too narrow for the key-violation bit");
      end
      if (KEY_W < 1 || KEY_W > 6) begin : g_bad_kw
         $error("key width out of supported range");
      end
   endgenerate

   logic [RIGHTS_W-1:0] rights;
   logic                key_ad;
   logic                key_wd;

   pkey_rights_reg #(.KEYS(KEYS), .SEL_W(SEL_W)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (rr_wr_en),
      .rd_en    (rr_rd_en),
      .sel      (rr_sel),
      .wr_data  (rr_wr_data),
      .ld_en    (ss_load_en),
      .ld_data  (ss_load_data),
      .rights   (rights),
      .rd_data  (rr_rd_data),
      .gp_fault (rr_gp_fault)
   );

   assign ss_image = rights;

   pkey_lookup #(
      .ENTRY_W (ENTRY_W),
      .KEY_LSB (KEY_LSB),
      .KEY_W   (KEY_W),
      .DECODED (LOOKUP_DECODED)
   ) u_lookup (
      .entry  (acc_entry),
      .rights (rights),
      .ad     (key_ad),
      .wd     (key_wd)
   );

   pkey_decide #(.ERR_W(ERR_W)) u_decide (
      .clk         (clk),
      .rst_n       (rst_n),
      .acc_valid   (acc_valid),
      .is_write    (acc_is_write),
      .is_user     (acc_is_user),
      .gate_en     (gate_en),
      .ad          (key_ad),
      .wd          (key_wd),
      .dec_valid   (dec_valid),
      .dec_allow   (dec_allow),
      .dec_errcode (dec_errcode)
   );

endmodule

// File: rtl/pkey_guard_chk.sv
module pkey_guard_chk #(
   parameter int SEL_W    = 32,
   parameter int ERR_W    = 16,
   parameter int RIGHTS_W = 32
) (
   input logic                clk,
   input logic                rst_n,
   input logic                acc_valid,
   input logic                acc_is_user,
   input logic                gate_en,
   input logic                dec_valid,
   input logic                dec_allow,
   input logic [ERR_W-1:0]    dec_errcode,
   input logic                rr_wr_en,
   input logic                rr_rd_en,
   input logic [SEL_W-1:0]    rr_sel,
   input logic                rr_gp_fault,
   input logic                ss_load_en,
   input logic [RIGHTS_W-1:0] ss_load_data,
   input logic [RIGHTS_W-1:0] ss_image
);

   // R7
   latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      acc_valid |=> dec_valid);

   // R4
   gate_off_allow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && !gate_en) |=> dec_allow);

   // R5
   supervisor_allow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && !acc_is_user) |=> dec_allow);

   // R6
   deny_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_valid && !dec_allow) |-> (dec_errcode[5] && dec_errcode[2] && dec_errcode[0]));

   // R10
   bad_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((rr_wr_en || rr_rd_en) && rr_sel != '0 && !ss_load_en) |=> ($stable(ss_image) && rr_gp_fault));

   // R12
   restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ss_load_en |=> (ss_image == $past(ss_load_data)));

endmodule

bind pkey_guard pkey_guard_chk #(
   .SEL_W    (SEL_W),
   .ERR_W    (ERR_W),
   .RIGHTS_W (RIGHTS_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .acc_valid    (acc_valid),
   .acc_is_user  (acc_is_user),
   .gate_en      (gate_en),
   .dec_valid    (dec_valid),
   .dec_allow    (dec_allow),
   .dec_errcode  (dec_errcode),
   .rr_wr_en     (rr_wr_en),
   .rr_rd_en     (rr_rd_en),
   .rr_sel       (rr_sel),
   .rr_gp_fault  (rr_gp_fault),
   .ss_load_en   (ss_load_en),
   .ss_load_data (ss_load_data),
   .ss_image     (ss_image)
);

// File: tb/tb_pkey_guard.sv
module tb_pkey_guard;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic        rst_n;
   logic        acc_valid, acc_is_write, acc_is_user, gate_en;
   logic [63:0] acc_entry;
   logic        dec_valid, dec_allow;
   logic [15:0] dec_errcode;
   logic        rr_wr_en, rr_rd_en;
   logic [31:0] rr_sel, rr_wr_data, rr_rd_data;
   logic        rr_gp_fault;
   logic        ss_load_en;
   logic [31:0] ss_load_data, ss_image;

   pkey_guard dut (
      .clk(clk), .rst_n(rst_n),
      .acc_valid(acc_valid), .acc_entry(acc_entry),
      .acc_is_write(acc_is_write), .acc_is_user(acc_is_user), .gate_en(gate_en),
      .dec_valid(dec_valid), .dec_allow(dec_allow), .dec_errcode(dec_errcode),
      .rr_wr_en(rr_wr_en), .rr_rd_en(rr_rd_en), .rr_sel(rr_sel),
      .rr_wr_data(rr_wr_data), .rr_rd_data(rr_rd_data), .rr_gp_fault(rr_gp_fault),
      .ss_load_en(ss_load_en), .ss_load_data(ss_load_data), .ss_image(ss_image)
   );

   int vectors = 0;
   int misses  = 0;
   bit done    = 1'b0;
   bit compare_on = 1'b0;

   // Behavioural reference model
   logic [31:0] m_rights, e_rd;
   logic        e_valid, e_allow, e_gp;
   logic [15:0] e_code;

   always @(posedge clk) begin
      int  key;
      bit  ad, wd, deny;
      if (!rst_n) begin
         m_rights <= 0; e_rd <= 0; e_valid <= 0; e_allow <= 0; e_gp <= 0; e_code <= 0;
      end else begin
         key  = int'(acc_entry[62:59]);
         ad   = m_rights[2*key];
         wd   = m_rights[2*key+1];
         deny = gate_en && acc_is_user && (ad || (wd && acc_is_write));
         e_valid <= acc_valid;
         e_allow <= acc_valid && !deny;
         e_code  <= (acc_valid && deny) ? (acc_is_write ? 16'h0027 : 16'h0025) : 16'h0000;
         e_gp    <= (rr_wr_en || rr_rd_en) && (rr_sel != 0);
         if (rr_rd_en && rr_sel == 0) e_rd <= m_rights;
         if (ss_load_en) m_rights <= ss_load_data;
         else if (rr_wr_en && rr_sel == 0) m_rights <= rr_wr_data;
      end
   end

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         misses++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (compare_on && !done) begin
         chk("R7 dec_valid", 32'(dec_valid), 32'(e_valid));
         chk("R1/R2/R3/R4/R5/R9 dec_allow", 32'(dec_allow), 32'(e_allow));
         chk("R6 dec_errcode", 32'(dec_errcode), 32'(e_code));
         chk("R10 rr_gp_fault", 32'(rr_gp_fault), 32'(e_gp));
         chk("R11 rr_rd_data", rr_rd_data, e_rd);
         chk("R9/R12 ss_image", ss_image, m_rights);
      end
   end

   task automatic idle();
      acc_valid = 0; acc_is_write = 0; acc_is_user = 0; gate_en = 1;
      acc_entry = 0; rr_wr_en = 0; rr_rd_en = 0; rr_sel = 0; rr_wr_data = 0;
      ss_load_en = 0; ss_load_data = 0;
   endtask

   task automatic access(int key, bit wr, bit user, bit en);
      @(negedge clk);
      idle();
      acc_valid    = 1;
      acc_entry    = {$urandom, $urandom};
      acc_entry[62:59] = 4'(key);
      acc_is_write = wr; acc_is_user = user; gate_en = en;
      @(negedge clk);
      idle();
   endtask

   task automatic reg_wr(logic [31:0] sel, logic [31:0] data);
      @(negedge clk);
      idle();
      rr_wr_en = 1; rr_sel = sel; rr_wr_data = data;
      @(negedge clk);
      idle();
   endtask

   task automatic reg_rd(logic [31:0] sel);
      @(negedge clk);
      idle();
      rr_rd_en = 1; rr_sel = sel;
      @(negedge clk);
      idle();
   endtask

   // Watchdog
   initial begin
      #(20 * 200000);
      if (!done) begin
         misses++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
         $finish;
      end
   end

   initial begin
      idle();
      rst_n = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R8: reset state
      chk("R8 reset ss_image", ss_image, 0);
      chk("R8 reset rr_rd_data", rr_rd_data, 0);
      chk("R8 reset dec_allow", 32'(dec_allow), 0);
      chk("R8 reset dec_errcode", 32'(dec_errcode), 0);
      chk("R8 reset rr_gp_fault", 32'(rr_gp_fault), 0);
      rst_n = 1;
      compare_on = 1;

      // R1: all keys open after reset
      for (int k = 0; k < 16; k++) access(k, k[0], 1'b1, 1'b1);

      // R2/R3: key 3 access-disable, key 7 write-disable, key 9 both
      reg_wr(0, (32'h1 << 6) | (32'h2 << 14) | (32'h3 << 18));
      for (int k = 2; k <= 10; k++) begin
         access(k, 1'b0, 1'b1, 1'b1);
         access(k, 1'b1, 1'b1, 1'b1);
      end
      // R4 and R5 bypasses
      for (int k = 3; k <= 9; k += 2) begin
         access(k, 1'b1, 1'b1, 1'b0);
         access(k, 1'b1, 1'b0, 1'b1);
      end

      // R9: write and access in same cycle, then next cycle
      @(negedge clk);
      idle();
      rr_wr_en = 1; rr_wr_data = 32'h1; acc_valid = 1; acc_is_user = 1;
      acc_entry[62:59] = 4'd0;
      @(negedge clk);
      idle();
      acc_valid = 1; acc_is_user = 1; acc_entry[62:59] = 4'd0;
      @(negedge clk);
      idle();

      // R10: illegal selectors
      reg_wr(32'h1, 32'hFFFF_FFFF);
      reg_rd(32'h8000_0000);
      access(0, 1'b0, 1'b1, 1'b1);
      // R11: legal read
      reg_rd(0);

      // R12: restore colliding with a write
      @(negedge clk);
      idle();
      ss_load_en = 1; ss_load_data = 32'hA5A5_5A5A;
      rr_wr_en = 1; rr_wr_data = 32'h0000_FFFF;
      @(negedge clk);
      idle();
      reg_rd(0);

      // Random mix
      for (int n = 0; n < 4000; n++) begin
         @(negedge clk);
         acc_valid    = $urandom_range(0, 3) != 0;
         acc_entry    = {$urandom, $urandom};
         acc_is_write = $urandom_range(0, 1) == 1;
         acc_is_user  = $urandom_range(0, 4) != 0;
         gate_en      = $urandom_range(0, 5) != 0;
         rr_wr_en     = $urandom_range(0, 7) == 0;
         rr_rd_en     = $urandom_range(0, 5) == 0;
         rr_sel       = ($urandom_range(0, 7) == 0) ? 32'(1 << $urandom_range(0, 31)) : 32'h0;
         rr_wr_data   = $urandom;
         ss_load_en   = $urandom_range(0, 31) == 0;
         ss_load_data = $urandom;
      end
      @(negedge clk);
      idle();
      repeat (3) @(negedge clk);

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
   end

endmodule